// File: doc/BRIEF.md
# Integer divide and remainder unit

This block computes the quotient or the remainder of two integer operands for a processor's execute stage. Signed and unsigned forms are both supported. When the operand width is 64, a word flag restricts the operation to the low 32 bits of each operand and sign-extends the 32-bit answer. A one-cycle `start` pulse launches an operation. `busy` stays high while the divider iterates. `done` pulses for one cycle when `result` becomes valid, and `result` then holds until the next operation completes.

Division by zero and signed overflow never trap. Each of these cases produces a fixed answer one cycle after `start`, without going through the divider. Every other case uses a restoring divider on the operand magnitudes, one quotient bit per cycle. Signs are applied to the quotient and remainder in a final cycle. The write enable accompanies `done` unless the destination register index is zero.

Top module: `divrem_unit`

## Requirements
- R1: `start` is accepted only while `busy` is low and `funct3[2]` is 1. Within an accepted operation, `funct3[0]`=1 selects unsigned and 0 selects signed, and `funct3[1]`=1 returns the remainder while 0 returns the quotient (100 DIV, 101 DIVU, 110 REM, 111 REMU). A `start` with `funct3[2]`=0 raises neither `busy` nor `done` and leaves `result` unchanged.
- R2: Signed division truncates toward zero. A nonzero signed remainder has the sign of the dividend.
- R3: Unsigned forms treat both operands as unsigned XLEN-bit values.
- R4: With a zero divisor the quotient is all ones, and the remainder is the dividend. In word mode that remainder is the dividend's low 32 bits, sign-extended.
- R5: For a signed operation on the most negative value divided by -1, the quotient is the most negative value and the remainder is 0. In word mode these values are taken at 32 bits.
- R6: With `word`=1 and XLEN=64, only `op_a[31:0]` and `op_b[31:0]` are used. Zero and overflow detection look at those bits only, and every result, unsigned ones included, is sign-extended from bit 31.
- R7: `we` is high exactly in the cycle where `done` is high and `rd` sampled at `start` was nonzero. With `rd`=0, `result` is still presented.
- R8: If the start cycle is cycle 0, a zero-divisor or overflow case raises `done` in cycle 1. Any other case raises `done` in cycle XLEN+2 and keeps `busy` high in cycles 1 to XLEN+1.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes on time with its own result, and the ignored request produces no `done`.
- R10: During reset and immediately after it, `busy`, `done`, `we` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, one cycle |
| funct3 | input | 3 | Operation select |
| word | input | 1 | 32-bit word form (XLEN=64 only) |
| op_a | input | XLEN | Dividend |
| op_b | input | XLEN | Divisor |
| rd | input | 5 | Destination register index |
| busy | output | 1 | Divider iterating |
| done | output | 1 | Result valid pulse |
| we | output | 1 | Register write enable |
| result | output | XLEN | Quotient or remainder |

## Verification
The bench builds the unit with XLEN=64, which is the only width at which the word flag has any effect. That width makes the sign-extension of 32-bit results observable, and it lets a divisor that is zero only in its low half test the zero detection of the word forms. It also gives the 66-cycle iterative latency, which is checked against the one-cycle latency of the fixed-answer cases. A 64-bit behavioural model scores the random operations, and hand-written vectors cover the sign combinations and both corner cases at both widths.

// File: rtl/divrem_unit.sv
module divrem_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      funct3,
  input  logic            word,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [4:0]      rd,
  output logic            busy,
  output logic            done,
  output logic            we,
  output logic [XLEN-1:0] result
);
  localparam bit HAS_WORD = (XLEN == 64);
  localparam int CW = $clog2(XLEN);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] quo, rem, dvs;
  logic            q_neg, r_neg, want_rem, wm_q, rdnz_q;

  function automatic logic [XLEN-1:0] wfix(input logic w, input logic [XLEN-1:0] v);
    logic [XLEN-1:0] o;
    o = v;
    if (w) begin
      o = {XLEN{v[31]}};
      o[31:0] = v[31:0];
    end
    return o;
  endfunction

  logic wm, sgn, accept, b_zero, ovf, a_neg, b_neg;
  logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag, min_w, corner_val;

  assign wm  = HAS_WORD && word;
  assign sgn = !funct3[0];

  always_comb begin
    a_ext = op_a;
    b_ext = op_b;
    if (wm) begin
      a_ext = {XLEN{sgn & op_a[31]}};
      a_ext[31:0] = op_a[31:0];
      b_ext = {XLEN{sgn & op_b[31]}};
      b_ext[31:0] = op_b[31:0];
    end
  end

  assign a_neg  = sgn & a_ext[XLEN-1];
  assign b_neg  = sgn & b_ext[XLEN-1];
  assign a_mag  = a_neg ? -a_ext : a_ext;
  assign b_mag  = b_neg ? -b_ext : b_ext;
  assign min_w  = {XLEN{1'b1}} << (wm ? 31 : XLEN - 1);
  assign b_zero = (b_ext == '0);
  assign ovf    = sgn && (a_ext == min_w) && (b_ext == {XLEN{1'b1}});
  assign accept = start && !busy && funct3[2];

  assign corner_val = b_zero ? (funct3[1] ? a_ext : {XLEN{1'b1}})
                             : (funct3[1] ? '0 : a_ext);

  logic [XLEN:0]   shifted, diff;
  logic            take;
  logic [XLEN-1:0] q_fin, r_fin;

  assign shifted = {rem, quo[XLEN-1]};
  assign diff    = shifted - {1'b0, dvs};
  assign take    = !diff[XLEN];
  assign q_fin   = q_neg ? -quo : quo;
  assign r_fin   = r_neg ? -rem : rem;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      q_neg    <= 1'b0;
      r_neg    <= 1'b0;
      want_rem <= 1'b0;
      wm_q     <= 1'b0;
      rdnz_q   <= 1'b0;
      done     <= 1'b0;
      we       <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      we   <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (b_zero || ovf) begin
            result <= wfix(wm, corner_val);
            done   <= 1'b1;
            we     <= (rd != 5'd0);
          end else begin
            quo      <= a_mag;
            rem      <= '0;
            dvs      <= b_mag;
            q_neg    <= a_neg ^ b_neg;
            r_neg    <= a_neg;
            want_rem <= funct3[1];
            wm_q     <= wm;
            rdnz_q   <= (rd != 5'd0);
            cnt      <= '0;
            st       <= S_RUN;
          end
        end
        S_RUN: begin
          rem <= take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
          quo <= {quo[XLEN-2:0], take};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(XLEN - 1)) st <= S_FIN;
        end
        S_FIN: begin
          result <= wfix(wm_q, want_rem ? r_fin : q_fin);
          done   <= 1'b1;
          we     <= rdnz_q;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module divrem_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [2:0]      funct3,
  input logic            word,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic            busy,
  input logic            done,
  input logic            we,
  input logic [XLEN-1:0] result
);
  logic acc, bz, full_ovf;
  assign acc      = start && !busy && funct3[2];
  assign bz       = (XLEN == 64 && word) ? (op_b[31:0] == 32'd0) : (op_b == '0);
  assign full_ovf = !word && !funct3[0] && (op_a == {1'b1, {(XLEN-1){1'b0}}})
                    && (op_b == {XLEN{1'b1}});

  assert_zero_quot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bz && !funct3[1] |=> done && (result == {XLEN{1'b1}}));

  assert_ovf_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && full_ovf && funct3[1] |=> done && (result == '0));

  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !funct3[2] |=> !busy && !done && $stable(result));

  assert_we_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> done);

  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind divrem_unit divrem_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_divrem_unit.sv
`timescale 1ns/1ps
module test_divrem_unit;
  localparam int XLEN = 64;
  localparam int NV = 18;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, word = 1'b0;
  logic [2:0] funct3 = 3'b000;
  logic [63:0] op_a = '0, op_b = '0;
  logic [4:0] rd = '0;
  logic busy, done, we;
  logic [63:0] result;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  divrem_unit #(.XLEN(XLEN)) i_divrem_unit (.*);

  localparam logic [195:0] VEC [NV] = '{
    {3'b100, 1'b0, 64'd20, 64'd3, 64'd6},
    {3'b100, 1'b0, 64'hFFFFFFFFFFFFFFEC, 64'd3, 64'hFFFFFFFFFFFFFFFA},
    {3'b110, 1'b0, 64'hFFFFFFFFFFFFFFEC, 64'd3, 64'hFFFFFFFFFFFFFFFE},
    {3'b110, 1'b0, 64'd20, 64'hFFFFFFFFFFFFFFFD, 64'd2},
    {3'b101, 1'b0, 64'hFFFFFFFFFFFFFFFF, 64'd2, 64'h7FFFFFFFFFFFFFFF},
    {3'b111, 1'b0, 64'd100, 64'd7, 64'd2},
    {3'b100, 1'b0, 64'd5, 64'd0, 64'hFFFFFFFFFFFFFFFF},
    {3'b111, 1'b0, 64'h123, 64'd0, 64'h123},
    {3'b100, 1'b0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000},
    {3'b110, 1'b0, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'd0},
    {3'b100, 1'b1, 64'hAAAAAAAAFFFFFFEC, 64'h5555555500000003, 64'hFFFFFFFFFFFFFFFA},
    {3'b101, 1'b1, 64'h00000000FFFFFFFF, 64'd1, 64'hFFFFFFFFFFFFFFFF},
    {3'b110, 1'b1, 64'h0000000080000001, 64'h0000000100000000, 64'hFFFFFFFF80000001},
    {3'b100, 1'b1, 64'h0000000080000000, 64'h00000000FFFFFFFF, 64'hFFFFFFFF80000000},
    {3'b110, 1'b1, 64'h0000000080000000, 64'h00000000FFFFFFFF, 64'd0},
    {3'b111, 1'b1, 64'h0000000100000007, 64'd5, 64'd2},
    {3'b101, 1'b1, 64'h0000000000001234, 64'hFFFFFFFF00000000, 64'hFFFFFFFFFFFFFFFF},
    {3'b111, 1'b0, 64'h0000000100000000, 64'h0000000100000001, 64'h0000000100000000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_corner(input logic [2:0] f3, input logic w, input logic [63:0] a, input logic [63:0] b);
    if (w) return (b[31:0] == 0) || (!f3[0] && a[31:0] == 32'h80000000 && b[31:0] == 32'hFFFFFFFF);
    return (b == 0) || (!f3[0] && a == 64'h8000000000000000 && b == '1);
  endfunction

  function automatic logic [63:0] model(input logic [2:0] f3, input logic w, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [31:0] r32, a32, b32;
    logic signed [63:0] sa, sb;
    logic signed [31:0] sa32, sb32;
    if (!w) begin
      sa = a; sb = b;
      if (b == 0) r = f3[1] ? a : '1;
      else if (!f3[0] && a == 64'h8000000000000000 && b == '1) r = f3[1] ? 64'd0 : a;
      else if (f3[0]) r = f3[1] ? a % b : a / b;
      else r = f3[1] ? sa % sb : sa / sb;
    end else begin
      a32 = a[31:0]; b32 = b[31:0]; sa32 = a32; sb32 = b32;
      if (b32 == 0) r32 = f3[1] ? a32 : '1;
      else if (!f3[0] && a32 == 32'h80000000 && b32 == '1) r32 = f3[1] ? 32'd0 : a32;
      else if (f3[0]) r32 = f3[1] ? a32 % b32 : a32 / b32;
      else r32 = f3[1] ? sa32 % sb32 : sa32 / sb32;
      r = {{32{r32[31]}}, r32};
    end
    return r;
  endfunction

  task automatic run_op(input logic [2:0] f3, input logic w, input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] rdi, output logic [63:0] res, output int lat, output logic wev);
    @(negedge clk);
    funct3 = f3; word = w; op_a = a; op_b = b; rd = rdi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result; wev = we;
  endtask

  task automatic score(input string tag, input logic [2:0] f3, input logic w, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] exp);
    logic [63:0] res; int lat; logic wev;
    int elat;
    run_op(f3, w, a, b, 5'd3, res, lat, wev);
    elat = is_corner(f3, w, a, b) ? 1 : XLEN + 2;
    chk(res == exp, tag, res, exp);
    chk(lat == elat, "R8 latency", 64'(lat), 64'(elat));
    chk(wev == 1'b1, "R7 we with rd nonzero", 64'(wev), 64'd1);
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] res, a, b, hold;
    logic [2:0] f3;
    logic w, wev;
    int lat;
    string tag;

    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && we == 0 && result == 0, "R10 reset state", {busy, done, we, result[60:0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && we == 0 && result == 0, "R10 after reset", {busy, done, we, result[60:0]}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      f3 = VEC[i][195:193]; w = VEC[i][192];
      a = VEC[i][191:128]; b = VEC[i][127:64];
      if (b == 0 || (w && b[31:0] == 0)) tag = "R4 zero divisor";
      else if (is_corner(f3, w, a, b)) tag = "R5 overflow";
      else if (w) tag = "R6 word form";
      else if (f3[0]) tag = "R3 unsigned";
      else tag = "R2 signed";
      score(tag, f3, w, a, b, VEC[i][63:0]);
    end

    for (int i = 0; i < 24; i++) begin
      f3 = {1'b1, 2'($urandom % 4)};
      w = 1'($urandom % 2);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 3 == 0) b = 64'($urandom % 1000) - 64'd500;
      if (i % 4 == 1) a = {{32{a[31]}}, a[31:0]};
      score(f3[0] ? "R3 random" : "R2 random", f3, w, a, b, model(f3, w, a, b));
    end

    run_op(3'b100, 1'b0, 64'd9, 64'd0, 5'd0, res, lat, wev);
    chk(wev == 1'b0, "R7 we low for rd zero", 64'(wev), 64'd0);
    chk(res == '1, "R7 result kept for rd zero", res, '1);
    run_op(3'b110, 1'b0, 64'd50, 64'd7, 5'd0, res, lat, wev);
    chk(wev == 1'b0 && res == 64'd1, "R7 iterative rd zero", {63'd0, wev} | res, 64'd1);

    @(negedge clk);
    funct3 = 3'b100; word = 1'b0; op_a = 64'd1000; op_b = 64'd10; rd = 5'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (9) begin @(negedge clk); lat++; end
    chk(busy == 1'b1, "R8 busy during run", 64'(busy), 64'd1);
    funct3 = 3'b111; op_a = 64'd77; op_b = 64'd0; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    chk(done == 1'b0, "R9 ignored start gives no done", 64'(done), 64'd0);
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(result == 64'd100, "R9 running op result", result, 64'd100);
    chk(lat == XLEN + 2, "R9 running op latency", 64'(lat), 64'(XLEN + 2));
    hold = result;
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9 no late done", {62'd0, busy, done}, 64'd0);
    end

    @(negedge clk);
    funct3 = 3'b000; op_a = 64'd6; op_b = 64'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(busy == 0 && done == 0 && result == hold, "R1 non-divide start ignored", result, hold);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule